// File: doc/BRIEF.md
# Shared Memory Port Arbiter with Deadlines

This block decides which of several requesting agents owns a single memory command port, and for how long. Each agent drives a request and receives a ready; the block drives a one-hot grant vector and tells the port whether the current owner has a command pending. An owner keeps the port for a programmed number of accepted commands, so a burst is not split up. A cycle ceiling stops a slow owner from holding the port for too long. While an agent waits, a countdown in units of four clocks runs. When it runs out, that agent moves ahead of the round-robin order at the next arbitration point.

Each agent has three values: a hold-cycle ceiling, a wait deadline and a command quota. Software reaches them through one indexed write port. It first writes a target select holding the agent number times the field stride. It then writes one of the three value addresses, and that write lands in the selected agent's slot. Reset loads fixed per-agent defaults, so the block arbitrates sensibly with no configuration at all.

Top module: `mem_port_arbiter`

## Requirements
- R1: While reset is asserted and right after it, grant_o, ready_o and mem_valid_o are all zero.
- R2: Reset defaults per agent are as follows. The hold ceiling is 0x1f for agents 0 to 2 and 0x04 for agents 3 and 4. The deadline value is 0xff for every agent. The command quota is 0x04 for agents 0, 3 and 4, and 0x10 for agents 1 and 2.
- R3: grant_o changes only after a clock edge at which the owner's command was accepted (mem_valid_o and mem_ready_i both high) or at which the port was idle (mem_valid_o low).
- R4: At most one grant bit is set, and it goes only to an agent whose request was high. ready_o is grant_o gated by mem_ready_i. mem_valid_o is high exactly when the granted agent requests.
- R5: An owner keeps the grant until the handshake that completes its command quota, or until it lowers its request. A quota of 0 acts like 1.
- R6: An owner also gives up the grant at the first accepted command that occurs once it has held the grant for at least its hold-ceiling number of cycles, even if its quota is not complete.
- R7: When no waiting agent has an expired deadline, the next owner is the first requester found when searching upward (with wrap-around) from the agent after the one granted last. After reset, the search starts at agent 0.
- R8: An agent that has requested without a grant for at least 4 × its deadline value clocks wins the next arbitration point over every agent whose deadline has not expired. Among agents with expired deadlines, the round-robin order applies.
- R9: Configuration uses cfg_addr codes 0 = target select, 1 = hold ceiling, 2 = deadline, 3 = command quota. The target agent is the select value divided by 8, with the low 3 bits ignored. A value write whose target is 5 or more changes no agent's settings.
- R10: The grant is registered. At an arbitration point where a requester exists, grant_o shows the new owner right after that clock edge. If no agent requests, grant_o goes to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register code |
| cfg_wdata | input | 8 | Configuration write data |
| req_i | input | 5 | Per-agent command request |
| ready_o | output | 5 | Per-agent command accepted this cycle |
| grant_o | output | 5 | One-hot port owner |
| mem_valid_o | output | 1 | Owner has a command on the port |
| mem_ready_i | input | 1 | Memory port accepts a command |

## Verification
The bench builds the block with its default parameters: five agents, 8-bit values, an 8-wide select stride and a ×4 deadline scale. The reset defaults are therefore exactly the ones the requirements list. To bring the rarer paths within a few dozen cycles, the bench reprograms single agents. A quota of 20 on agent 3 makes its 4-cycle ceiling the release cause. A deadline value of 1 on agent 2 makes its wait expire after four clocks, which lets it jump the round-robin order. A select with low bits set, and a select beyond the last agent, exercise the index decode.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef enum logic [1:0] {
        CFG_SEL    = 2'd0,
        CFG_MINLIM = 2'd1,
        CFG_PERIOD = 2'd2,
        CFG_MINCMD = 2'd3
    } cfg_addr_e;

    function automatic int dflt_min_limit(int agent);
        return (agent < 3) ? 'h1f : 'h04;
    endfunction

    function automatic int dflt_period(int agent);
        return (agent >= 0) ? 'hff : 'hff;
    endfunction

    function automatic int dflt_min_cmd(int agent);
        return (agent == 1 || agent == 2) ? 'h10 : 'h04;
    endfunction

endpackage

// File: rtl/arb_cfg_regs.sv
module arb_cfg_regs #(
    parameter int NUM_AGENTS = 5,
    parameter int VAL_W      = 8,
    parameter int FIELD_W    = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cfg_we,
    input  logic [1:0]                       cfg_addr,
    input  logic [VAL_W-1:0]                 cfg_wdata,
    output logic [NUM_AGENTS-1:0][VAL_W-1:0] min_lim_o,
    output logic [NUM_AGENTS-1:0][VAL_W-1:0] period_o,
    output logic [NUM_AGENTS-1:0][VAL_W-1:0] min_cmd_o
);
    import arb_pkg::*;

    localparam int SHIFT = $clog2(FIELD_W);

    typedef struct packed {
        logic [VAL_W-1:0]                 sel;
        logic [NUM_AGENTS-1:0][VAL_W-1:0] min_lim;
        logic [NUM_AGENTS-1:0][VAL_W-1:0] period;
        logic [NUM_AGENTS-1:0][VAL_W-1:0] min_cmd;
    } cfg_t;

    cfg_t             st_d, st_q;
    logic [VAL_W-1:0] tgt;
    logic             tgt_ok;

    function automatic cfg_t reset_val();
        cfg_t r;
        r.sel = '0;
        for (int i = 0; i < NUM_AGENTS; i++) begin
            r.min_lim[i] = VAL_W'(dflt_min_limit(i));
            r.period[i]  = VAL_W'(dflt_period(i));
            r.min_cmd[i] = VAL_W'(dflt_min_cmd(i));
        end
        return r;
    endfunction

    assign tgt    = st_q.sel >> SHIFT;
    assign tgt_ok = (tgt < VAL_W'(NUM_AGENTS));

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            case (cfg_addr_e'(cfg_addr))
                CFG_SEL: st_d.sel = cfg_wdata;
                CFG_MINLIM: begin
                    for (int i = 0; i < NUM_AGENTS; i++)
                        if (tgt_ok && tgt == VAL_W'(i)) st_d.min_lim[i] = cfg_wdata;
                end
                CFG_PERIOD: begin
                    for (int i = 0; i < NUM_AGENTS; i++)
                        if (tgt_ok && tgt == VAL_W'(i)) st_d.period[i] = cfg_wdata;
                end
                default: begin
                    for (int i = 0; i < NUM_AGENTS; i++)
                        if (tgt_ok && tgt == VAL_W'(i)) st_d.min_cmd[i] = cfg_wdata;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= reset_val();
        else        st_q <= st_d;
    end

    assign min_lim_o = st_q.min_lim;
    assign period_o  = st_q.period;
    assign min_cmd_o = st_q.min_cmd;

    // R9: value writes aimed beyond the last agent leave every slot untouched
    a_r9_out_of_range_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr != 2'(CFG_SEL) && (st_q.sel >> SHIFT) >= VAL_W'(NUM_AGENTS))
        |=> ($stable(min_lim_o) && $stable(period_o) && $stable(min_cmd_o)));

endmodule

// File: rtl/arb_deadline.sv
module arb_deadline #(
    parameter int VAL_W        = 8,
    parameter int PERIOD_SCALE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             granted,
    input  logic [VAL_W-1:0] period,
    output logic             urgent
);
    localparam int CNT_W = VAL_W + $clog2(PERIOD_SCALE);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] limit;

    assign limit = CNT_W'(period) * CNT_W'(PERIOD_SCALE);

    always_comb begin
        cnt_d = cnt_q;
        if (!req || granted)   cnt_d = '0;
        else if (cnt_q < limit) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign urgent = req && !granted && (cnt_q >= limit);

endmodule

// File: rtl/arb_pick.sv
module arb_pick #(
    parameter int NUM_AGENTS = 5,
    parameter int IDX_W      = $clog2(NUM_AGENTS)
) (
    input  logic [NUM_AGENTS-1:0] req,
    input  logic [NUM_AGENTS-1:0] urgent,
    input  logic [IDX_W-1:0]      last,
    output logic                  pick_valid,
    output logic [IDX_W-1:0]      pick_idx
);
    logic             hit_urg, hit_any;
    logic [IDX_W-1:0] idx_urg, idx_any;

    always_comb begin
        hit_urg = 1'b0;
        hit_any = 1'b0;
        idx_urg = '0;
        idx_any = '0;
        for (int off = 1; off <= NUM_AGENTS; off++) begin
            int idx;
            idx = int'(last) + off;
            if (idx >= NUM_AGENTS) idx = idx - NUM_AGENTS;
            if (urgent[idx] && !hit_urg) begin
                hit_urg = 1'b1;
                idx_urg = IDX_W'(idx);
            end
            if (req[idx] && !hit_any) begin
                hit_any = 1'b1;
                idx_any = IDX_W'(idx);
            end
        end
        pick_valid = hit_any;
        pick_idx   = hit_urg ? idx_urg : idx_any;
    end

endmodule

// File: rtl/mem_port_arbiter.sv
module mem_port_arbiter #(
    parameter int NUM_AGENTS   = 5,
    parameter int VAL_W        = 8,
    parameter int FIELD_W      = 8,
    parameter int PERIOD_SCALE = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [1:0]            cfg_addr,
    input  logic [VAL_W-1:0]      cfg_wdata,
    input  logic [NUM_AGENTS-1:0] req_i,
    output logic [NUM_AGENTS-1:0] ready_o,
    output logic [NUM_AGENTS-1:0] grant_o,
    output logic                  mem_valid_o,
    input  logic                  mem_ready_i
);
    localparam int IDX_W = $clog2(NUM_AGENTS);

    typedef struct packed {
        logic [NUM_AGENTS-1:0] grant;
        logic [IDX_W-1:0]      owner;
        logic [IDX_W-1:0]      last;
        logic [VAL_W-1:0]      cmd;
        logic [VAL_W-1:0]      cyc;
    } arb_t;

    arb_t st_d, st_q;

    logic [NUM_AGENTS-1:0][VAL_W-1:0] min_lim_w, period_w, min_cmd_w;
    logic [NUM_AGENTS-1:0]            urgent_w;
    logic                             pick_valid;
    logic [IDX_W-1:0]                 pick_idx;
    logic                             owner_req, fire, quota_done, ceil_hit, arb_pt;

    arb_cfg_regs #(
        .NUM_AGENTS(NUM_AGENTS), .VAL_W(VAL_W), .FIELD_W(FIELD_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .min_lim_o(min_lim_w), .period_o(period_w),
        .min_cmd_o(min_cmd_w)
    );

    for (genvar g = 0; g < NUM_AGENTS; g++) begin : g_deadline
        arb_deadline #(
            .VAL_W(VAL_W), .PERIOD_SCALE(PERIOD_SCALE)
        ) u_dl (
            .clk(clk), .rst_n(rst_n), .req(req_i[g]), .granted(st_q.grant[g]),
            .period(period_w[g]), .urgent(urgent_w[g])
        );
    end

    arb_pick #(
        .NUM_AGENTS(NUM_AGENTS), .IDX_W(IDX_W)
    ) u_pick (
        .req(req_i), .urgent(urgent_w), .last(st_q.last),
        .pick_valid(pick_valid), .pick_idx(pick_idx)
    );

    assign owner_req  = |(req_i & st_q.grant);
    assign fire       = owner_req && mem_ready_i;
    assign quota_done = ({1'b0, st_q.cmd} + 1'b1) >= {1'b0, min_cmd_w[st_q.owner]};
    assign ceil_hit   = st_q.cyc >= min_lim_w[st_q.owner];
    assign arb_pt     = !owner_req || (fire && (quota_done || ceil_hit));

    always_comb begin
        st_d = st_q;
        if (st_q.grant != '0 && st_q.cyc != '1) st_d.cyc = st_q.cyc + 1'b1;
        if (fire) st_d.cmd = st_q.cmd + 1'b1;
        if (arb_pt) begin
            st_d.cmd = '0;
            st_d.cyc = '0;
            if (pick_valid) begin
                st_d.grant = NUM_AGENTS'(1) << pick_idx;
                st_d.owner = pick_idx;
                st_d.last  = pick_idx;
            end else begin
                st_d.grant = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.last  <= IDX_W'(NUM_AGENTS - 1);
        end else begin
            st_q <= st_d;
        end
    end

    assign grant_o     = st_q.grant;
    assign ready_o     = st_q.grant & {NUM_AGENTS{mem_ready_i}};
    assign mem_valid_o = owner_req;

    // R4: never more than one owner
    a_r4_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    // R4: a fresh grant lands only on an agent that was requesting
    a_r4_grant_to_requester: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o != '0 && grant_o != $past(grant_o)) |-> (($past(req_i) & grant_o) != '0));

    // R3: ownership moves only after an accepted command or an idle cycle
    a_r3_move_at_handshake: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o != $past(grant_o)) |-> ($past(mem_valid_o && mem_ready_i) || !$past(mem_valid_o)));

    // R5: an accepted command below quota and ceiling keeps the owner
    a_r5_hold_until_quota: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid_o && mem_ready_i &&
         (({1'b0, st_q.cmd} + 1'b1) < {1'b0, min_cmd_w[st_q.owner]}) &&
         (st_q.cyc < min_lim_w[st_q.owner]))
        |=> (grant_o == $past(grant_o)));

endmodule

// File: tb/tb_mem_port_arbiter.sv
`timescale 1ns/1ps
module tb_mem_port_arbiter;
    localparam int N = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_we = 1'b0;
    logic [1:0]   cfg_addr = '0;
    logic [7:0]   cfg_wdata = '0;
    logic [N-1:0] req_i = '0;
    logic [N-1:0] ready_o, grant_o;
    logic         mem_valid_o;
    logic         mem_ready_i = 1'b1;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    mem_port_arbiter dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .req_i(req_i), .ready_o(ready_o),
        .grant_o(grant_o), .mem_valid_o(mem_valid_o), .mem_ready_i(mem_ready_i)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_i = '0;
        mem_ready_i = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic cfg_write(input logic [1:0] a, input logic [7:0] d);
        cfg_addr = a;
        cfg_wdata = d;
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // counts consecutive sampled cycles with the current grant
    task automatic get_run(output int who, output int len);
        logic [N-1:0] g;
        g = grant_o;
        who = -1;
        for (int i = 0; i < N; i++) if (g[i]) who = i;
        len = 0;
        while (grant_o == g && len < 400) begin
            len++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        req_i = '1;
        repeat (2) @(negedge clk);
        check(grant_o == '0, "R1 grant in reset", int'(grant_o), 0);
        check(ready_o == '0, "R1 ready in reset", int'(ready_o), 0);
        rst_n = 1'b1;
        req_i = '0;
        @(negedge clk);
        check(!mem_valid_o && grant_o == '0, "R1 idle after reset", int'(grant_o), 0);
    endtask

    task automatic t_defaults_rr();
        int who, len;
        do_reset();
        req_i = 5'b01011;
        @(negedge clk);
        check(grant_o == 5'b00001, "R10 first grant one edge later", int'(grant_o), 1);
        get_run(who, len);
        check(who == 0, "R7 first owner", who, 0);
        check(len == 4, "R2 R5 agent0 quota", len, 4);
        check(ready_o == 5'b00010 && mem_valid_o, "R4 ready follows grant", int'(ready_o), 2);
        get_run(who, len);
        check(who == 1, "R7 second owner", who, 1);
        check(len == 16, "R2 R5 agent1 quota", len, 16);
        get_run(who, len);
        check(who == 3, "R7 third owner", who, 3);
        check(len == 4, "R2 agent3 quota", len, 4);
        get_run(who, len);
        check(who == 0, "R7 wrap to agent0", who, 0);
        req_i = '0;
    endtask

    task automatic t_stall();
        int who, len;
        do_reset();
        mem_ready_i = 1'b0;
        req_i = 5'b00011;
        @(negedge clk);
        check(grant_o == 5'b00001, "R10 grant under stall", int'(grant_o), 1);
        repeat (20) @(negedge clk);
        check(grant_o == 5'b00001, "R3 grant held while stalled", int'(grant_o), 1);
        check(ready_o == '0, "R4 no ready while port stalls", int'(ready_o), 0);
        check(mem_valid_o, "R4 valid while owner requests", int'(mem_valid_o), 1);
        mem_ready_i = 1'b1;
        get_run(who, len);
        check(len == 4, "R5 quota after stall", len, 4);
        check(grant_o == 5'b00010, "R7 next after stall", int'(grant_o), 2);
        req_i = '0;
    endtask

    task automatic t_drop();
        do_reset();
        req_i = 5'b00110;
        @(negedge clk);
        check(grant_o == 5'b00010, "R7 search starts at agent0", int'(grant_o), 2);
        repeat (2) @(negedge clk);
        req_i[1] = 1'b0;
        #1;
        check(!mem_valid_o, "R4 valid drops with owner request", int'(mem_valid_o), 0);
        @(negedge clk);
        check(grant_o == 5'b00100, "R5 release on request drop", int'(grant_o), 4);
        req_i = '0;
        @(negedge clk);
        @(negedge clk);
        check(grant_o == '0, "R10 no requester clears grant", int'(grant_o), 0);
    endtask

    task automatic t_ceiling();
        int who, len;
        do_reset();
        cfg_write(2'd0, 8'd24);
        cfg_write(2'd3, 8'd20);
        req_i = 5'b11000;
        @(negedge clk);
        get_run(who, len);
        check(who == 3, "R6 owner agent3", who, 3);
        check(len == 5, "R6 R9 ceiling ends hold", len, 5);
        get_run(who, len);
        check(who == 4, "R7 agent4 next", who, 4);
        check(len == 4, "R2 agent4 quota", len, 4);
        req_i = '0;
    endtask

    task automatic t_deadline();
        int who, len;
        do_reset();
        cfg_write(2'd0, 8'd16);
        cfg_write(2'd2, 8'd1);
        req_i = 5'b00111;
        @(negedge clk);
        get_run(who, len);
        check(who == 0 && len == 4, "R8 agent0 first hold", len, 4);
        check(grant_o == 5'b00100, "R8 expired agent2 jumps agent1", int'(grant_o), 4);
        get_run(who, len);
        check(len == 16, "R2 agent2 quota", len, 16);
        check(grant_o == 5'b00001, "R7 order resumes after agent2", int'(grant_o), 1);
        req_i = '0;
    endtask

    task automatic t_cfg_index();
        int who, len;
        do_reset();
        cfg_write(2'd0, 8'd13);
        cfg_write(2'd3, 8'd2);
        cfg_write(2'd0, 8'd40);
        cfg_write(2'd3, 8'd1);
        cfg_write(2'd1, 8'd0);
        req_i = 5'b00011;
        @(negedge clk);
        get_run(who, len);
        check(who == 0 && len == 4, "R9 agent0 untouched", len, 4);
        get_run(who, len);
        check(who == 1, "R9 agent1 owner", who, 1);
        check(len == 2, "R9 low select bits ignored", len, 2);
        get_run(who, len);
        check(who == 0 && len == 4, "R9 out of range write ignored", len, 4);
        req_i = '0;
    endtask

    initial begin
        #(4 * 20000);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_defaults_rr();
        t_stall();
        t_drop();
        t_ceiling();
        t_deadline();
        t_cfg_index();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule